// File: doc/BRIEF.md
# I2C Multi-Payload Transaction Sequencer

This block turns one command into an ordered series of I2C payloads and drives a byte-level bus engine through them. A command names how many payloads to run. Each payload is read from a descriptor port, indexed by the sequencer, and gives a 7-bit target address, a direction and a byte count. For every payload the sequencer asks the engine for a START condition, then the address byte, then either data bytes pulled from a write stream or data bytes pushed into a read stream.

Payloads are chained with repeated STARTs. A STOP is requested only once the final payload has finished, or straight away when any step fails, and a failure drops every payload that has not yet run. Before the first payload the sequencer must win the bus from an external arbiter, and it tries a bounded number of times with a fixed pause between tries. The end of each command is reported by a one-cycle done pulse that carries a pass/fail bit. Bit timing on the wires belongs to the engine and is outside this block.

Top module: `i2c_txn_seq`

## Requirements
- R1: After reset, done, eng_go, acq_try, wr_pop and rd_valid are low and desc_idx is 0.
- R2: The bus is requested by pulsing acq_try while acq_ok is sampled. There are at most ACQ_TRIES tries and PAUSE_CYC idle cycles between tries. If every try is refused, the command ends with done_ok = 0 and no engine operation is issued.
- R3: Engine operations are coded on eng_op as 0 = START, 1 = STOP, 2 = WRITE byte, 3 = READ byte. Each eng_go is a single-cycle pulse. A new operation is never issued while one is still waiting for eng_done. Every payload begins with a START, and that START is a repeated START for every payload after the first.
- R4: The byte written right after each START is the payload address in bits 7:1, with bit 0 set to 1 for a read and 0 for a write.
- R5: In a write payload, each data byte is taken from wr_byte in the same cycle as a wr_pop pulse, which coincides with the WRITE eng_go. Bytes are taken in stream order, one pop per byte.
- R6: A WRITE that finishes with eng_ack = 0, whether it carries the address or a data byte, fails the payload. A STOP follows at once, the command ends with done_ok = 0, and no later payload is started.
- R7: In a read payload, each byte is fetched with a READ operation. eng_last is 1 only on the READ of the payload's final byte, which is the byte to be answered with NACK. Each fetched byte appears on rd_byte with a one-cycle rd_valid, in order.
- R8: Between two successful payloads of one command no STOP is issued. After the last payload succeeds, exactly one STOP is issued, and the command ends with done_ok = 1 when that STOP succeeds.
- R9: A START or STOP that finishes with eng_ack = 0 makes the command fail. A failed START is still followed by a STOP.
- R10: A payload with a byte count of zero performs its START and address byte, and the address byte's acknowledge still decides whether the payload passes.
- R11: Each command produces exactly one single-cycle done pulse. A cmd_start raised while a command is running is ignored.
- R12: A command with cmd_count = 0 ends with done_ok = 1 without touching the bus or the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Strobe that begins a command when idle |
| cmd_count | input | PL_W | Number of payloads in the command |
| desc_idx | output | PL_W | Index of the descriptor being read |
| desc_addr | input | 7 | Target address of the indexed payload |
| desc_read | input | 1 | 1 = read payload, 0 = write payload |
| desc_len | input | LEN_W | Data byte count of the indexed payload |
| wr_pop | output | 1 | Consumes wr_byte this cycle |
| wr_byte | input | 8 | Head of the write byte stream |
| rd_valid | output | 1 | rd_byte holds a fetched byte |
| rd_byte | output | 8 | Byte fetched from the bus |
| acq_try | output | 1 | Bus request, acq_ok sampled this cycle |
| acq_ok | input | 1 | Arbiter grants the bus |
| eng_go | output | 1 | Issues the operation on eng_op |
| eng_op | output | 2 | Operation code (see R3) |
| eng_wbyte | output | 8 | Byte for a WRITE operation |
| eng_last | output | 1 | READ is the payload's last byte (answer with NACK) |
| eng_done | input | 1 | Engine finished the outstanding operation |
| eng_ack | input | 1 | Acknowledge received / condition completed |
| eng_rbyte | input | 8 | Byte returned by a READ |
| done | output | 1 | One-cycle command completion pulse |
| done_ok | output | 1 | Completion status, valid with done |

## Verification
The bench builds the sequencer with PAUSE_CYC = 6, ACQ_TRIES = 2, PL_W = 3 and LEN_W = 4. The short pause lets the exact gap between two bus requests be measured cycle for cycle, and a refused second try is reached within a few cycles. The narrow payload and length fields keep the descriptor table at eight entries while still allowing commands that mix writes, reads and zero-length payloads, with a NACK injected into the middle of a multi-payload chain.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

   localparam int unsigned TGT_ADDR_W = 7;

   typedef enum logic [1:0] {
      OP_START = 2'd0,
      OP_STOP  = 2'd1,
      OP_WRITE = 2'd2,
      OP_READ  = 2'd3
   } bus_op_e;

   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_ACQ,
      SQ_START,
      SQ_ADDR,
      SQ_DATA,
      SQ_STOP
   } seq_st_e;

endpackage

// File: rtl/i2c_seq_acquire.sv
module i2c_seq_acquire #(
   parameter int unsigned TRIES = 2,
   parameter int unsigned PAUSE = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic bus_ok,
   output logic try_o,
   output logic grant_o,
   output logic deny_o
);

   localparam int unsigned TRY_W   = $clog2(TRIES + 1);
   localparam int unsigned PAUSE_W = (PAUSE > 0) ? $clog2(PAUSE + 1) : 1;

   typedef enum logic [1:0] {A_IDLE, A_TRY, A_WAIT} acq_st_e;

   acq_st_e          st;
   logic [TRY_W-1:0] tries;
   logic             last_try;
   logic             refused;
   logic             wait_done;
   logic             load_pause;

   assign try_o      = (st == A_TRY);
   assign last_try   = (tries == TRY_W'(TRIES - 1));
   assign refused    = try_o && !bus_ok;
   assign load_pause = refused && !last_try;

   generate
      if (PAUSE > 0) begin : g_pause
         logic [PAUSE_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (load_pause) begin
               cnt <= PAUSE_W'(PAUSE - 1);
            end else if (st == A_WAIT && cnt != '0) begin
               cnt <= cnt - 1'b1;
            end
         end
         assign wait_done = (cnt == '0);
      end else begin : g_nopause
         assign wait_done = 1'b1;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= A_IDLE;
         tries   <= '0;
         grant_o <= 1'b0;
         deny_o  <= 1'b0;
      end else begin
         grant_o <= 1'b0;
         deny_o  <= 1'b0;
         case (st)
            A_IDLE: begin
               if (start) begin
                  st    <= A_TRY;
                  tries <= '0;
               end
            end
            A_TRY: begin
               if (bus_ok) begin
                  grant_o <= 1'b1;
                  st      <= A_IDLE;
               end else if (last_try) begin
                  deny_o <= 1'b1;
                  st     <= A_IDLE;
               end else begin
                  tries <= tries + 1'b1;
                  st    <= (PAUSE == 0) ? A_TRY : A_WAIT;
               end
            end
            A_WAIT: begin
               if (wait_done) st <= A_TRY;
            end
            default: st <= A_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/i2c_seq_payload.sv
module i2c_seq_payload #(
   parameter int unsigned PL_W  = 4,
   parameter int unsigned LEN_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_cmd,
   input  logic [PL_W-1:0]  cmd_count,
   input  logic             load_desc,
   input  logic [6:0]       d_addr,
   input  logic             d_read,
   input  logic [LEN_W-1:0] d_len,
   input  logic             byte_step,
   input  logic             next_pl,
   output logic [PL_W-1:0]  idx_o,
   output logic [7:0]       addr_byte_o,
   output logic             is_read_o,
   output logic             rem_zero_o,
   output logic             rem_one_o,
   output logic             last_pl_o
);

   logic [PL_W-1:0]  cnt_q;
   logic [PL_W-1:0]  idx_q;
   logic [6:0]       addr_q;
   logic             rd_q;
   logic [LEN_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         idx_q <= '0;
      end else if (load_cmd) begin
         cnt_q <= cmd_count;
         idx_q <= '0;
      end else if (next_pl) begin
         idx_q <= idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         rd_q   <= 1'b0;
         rem_q  <= '0;
      end else if (load_desc) begin
         addr_q <= d_addr;
         rd_q   <= d_read;
         rem_q  <= d_len;
      end else if (byte_step) begin
         rem_q <= rem_q - 1'b1;
      end
   end

   assign idx_o       = idx_q;
   assign addr_byte_o = {addr_q, rd_q};
   assign is_read_o   = rd_q;
   assign rem_zero_o  = (rem_q == '0);
   assign rem_one_o   = (rem_q == LEN_W'(1));
   assign last_pl_o   = (idx_q == PL_W'(cnt_q - 1'b1));

endmodule

// File: rtl/i2c_seq_ctl.sv
module i2c_seq_ctl
   import i2c_seq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       cmd_start,
   input  logic       cmd_zero,
   input  logic       grant,
   input  logic       deny,
   input  logic       is_read,
   input  logic       rem_zero,
   input  logic       rem_one,
   input  logic       last_pl,
   input  logic [7:0] addr_byte,
   input  logic [7:0] wr_byte,
   input  logic       eng_done,
   input  logic       eng_ack,
   input  logic [7:0] eng_rbyte,
   output logic       acq_start,
   output logic       load_cmd,
   output logic       load_desc,
   output logic       byte_step,
   output logic       next_pl,
   output logic       eng_go,
   output logic [1:0] eng_op,
   output logic [7:0] eng_wbyte,
   output logic       eng_last,
   output logic       wr_pop,
   output logic       rd_valid,
   output logic [7:0] rd_byte,
   output logic       done,
   output logic       done_ok
);

   seq_st_e st;
   logic    issued;
   logic    fail_q;
   logic    fin;
   logic    op_state;
   logic    pl_end;
   bus_op_e op_sel;
   seq_st_e pl_exit;

   assign op_state = (st == SQ_START) || (st == SQ_ADDR) ||
                     (st == SQ_DATA)  || (st == SQ_STOP);
   assign eng_go   = op_state && !issued;
   assign fin      = issued && eng_done;

   always_comb begin
      case (st)
         SQ_STOP: op_sel = OP_STOP;
         SQ_ADDR: op_sel = OP_WRITE;
         SQ_DATA: op_sel = is_read ? OP_READ : OP_WRITE;
         default: op_sel = OP_START;
      endcase
   end

   assign eng_op    = op_sel;
   assign eng_wbyte = (st == SQ_ADDR) ? addr_byte :
                      (st == SQ_DATA && !is_read) ? wr_byte : 8'h00;
   assign eng_last  = (st == SQ_DATA) && is_read && rem_one;
   assign wr_pop    = eng_go && (st == SQ_DATA) && !is_read;

   assign load_cmd  = (st == SQ_IDLE) && cmd_start && !cmd_zero;
   assign acq_start = load_cmd;
   assign load_desc = eng_go && (st == SQ_START);
   assign byte_step = fin && (st == SQ_DATA) && (is_read || eng_ack);

   assign pl_end  = (fin && st == SQ_ADDR && eng_ack && rem_zero) ||
                    (fin && st == SQ_DATA && (is_read || eng_ack) && rem_one);
   assign next_pl = pl_end && !last_pl;
   assign pl_exit = last_pl ? SQ_STOP : SQ_START;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= SQ_IDLE;
         issued   <= 1'b0;
         fail_q   <= 1'b0;
         done     <= 1'b0;
         done_ok  <= 1'b0;
         rd_valid <= 1'b0;
         rd_byte  <= '0;
      end else begin
         done     <= 1'b0;
         rd_valid <= 1'b0;
         if (eng_go) issued <= 1'b1;
         else if (fin) issued <= 1'b0;
         case (st)
            SQ_IDLE: begin
               if (cmd_start) begin
                  fail_q <= 1'b0;
                  if (cmd_zero) begin
                     done    <= 1'b1;
                     done_ok <= 1'b1;
                  end else begin
                     st <= SQ_ACQ;
                  end
               end
            end
            SQ_ACQ: begin
               if (grant) begin
                  st <= SQ_START;
               end else if (deny) begin
                  done    <= 1'b1;
                  done_ok <= 1'b0;
                  st      <= SQ_IDLE;
               end
            end
            SQ_START: begin
               if (fin) begin
                  if (eng_ack) st <= SQ_ADDR;
                  else begin
                     fail_q <= 1'b1;
                     st     <= SQ_STOP;
                  end
               end
            end
            SQ_ADDR: begin
               if (fin) begin
                  if (!eng_ack) begin
                     fail_q <= 1'b1;
                     st     <= SQ_STOP;
                  end else if (rem_zero) begin
                     st <= pl_exit;
                  end else begin
                     st <= SQ_DATA;
                  end
               end
            end
            SQ_DATA: begin
               if (fin) begin
                  if (is_read) begin
                     rd_valid <= 1'b1;
                     rd_byte  <= eng_rbyte;
                  end
                  if (!is_read && !eng_ack) begin
                     fail_q <= 1'b1;
                     st     <= SQ_STOP;
                  end else if (rem_one) begin
                     st <= pl_exit;
                  end
               end
            end
            SQ_STOP: begin
               if (fin) begin
                  done    <= 1'b1;
                  done_ok <= !fail_q && eng_ack;
                  st      <= SQ_IDLE;
               end
            end
            default: st <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/i2c_txn_seq.sv
module i2c_txn_seq #(
   parameter int unsigned PL_W      = 4,
   parameter int unsigned LEN_W     = 8,
   parameter int unsigned ACQ_TRIES = 2,
   parameter int unsigned PAUSE_CYC = 500
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_start,
   input  logic [PL_W-1:0]  cmd_count,
   output logic [PL_W-1:0]  desc_idx,
   input  logic [6:0]       desc_addr,
   input  logic             desc_read,
   input  logic [LEN_W-1:0] desc_len,
   output logic             wr_pop,
   input  logic [7:0]       wr_byte,
   output logic             rd_valid,
   output logic [7:0]       rd_byte,
   output logic             acq_try,
   input  logic             acq_ok,
   output logic             eng_go,
   output logic [1:0]       eng_op,
   output logic [7:0]       eng_wbyte,
   output logic             eng_last,
   input  logic             eng_done,
   input  logic             eng_ack,
   input  logic [7:0]       eng_rbyte,
   output logic             done,
   output logic             done_ok
);

   generate
      if (PL_W < 1) begin : g_bad_pl
         $error("PL_W must be at least 1");
      end
      if (LEN_W < 1) begin : g_bad_len
         $error("LEN_W must be at least 1");
      end
      if (ACQ_TRIES < 1) begin : g_bad_tries
         $error("ACQ_TRIES must be at least 1");
      end
   endgenerate

   logic       acq_start, grant, deny;
   logic       load_cmd, load_desc, byte_step, next_pl;
   logic       is_read, rem_zero, rem_one, last_pl;
   logic [7:0] addr_byte;
   logic       cmd_zero;

   assign cmd_zero = (cmd_count == '0);

   i2c_seq_acquire #(
      .TRIES (ACQ_TRIES),
      .PAUSE (PAUSE_CYC)
   ) u_acq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (acq_start),
      .bus_ok  (acq_ok),
      .try_o   (acq_try),
      .grant_o (grant),
      .deny_o  (deny)
   );

   i2c_seq_payload #(
      .PL_W  (PL_W),
      .LEN_W (LEN_W)
   ) u_pl (
      .clk         (clk),
      .rst_n       (rst_n),
      .load_cmd    (load_cmd),
      .cmd_count   (cmd_count),
      .load_desc   (load_desc),
      .d_addr      (desc_addr),
      .d_read      (desc_read),
      .d_len       (desc_len),
      .byte_step   (byte_step),
      .next_pl     (next_pl),
      .idx_o       (desc_idx),
      .addr_byte_o (addr_byte),
      .is_read_o   (is_read),
      .rem_zero_o  (rem_zero),
      .rem_one_o   (rem_one),
      .last_pl_o   (last_pl)
   );

   i2c_seq_ctl u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_start (cmd_start),
      .cmd_zero  (cmd_zero),
      .grant     (grant),
      .deny      (deny),
      .is_read   (is_read),
      .rem_zero  (rem_zero),
      .rem_one   (rem_one),
      .last_pl   (last_pl),
      .addr_byte (addr_byte),
      .wr_byte   (wr_byte),
      .eng_done  (eng_done),
      .eng_ack   (eng_ack),
      .eng_rbyte (eng_rbyte),
      .acq_start (acq_start),
      .load_cmd  (load_cmd),
      .load_desc (load_desc),
      .byte_step (byte_step),
      .next_pl   (next_pl),
      .eng_go    (eng_go),
      .eng_op    (eng_op),
      .eng_wbyte (eng_wbyte),
      .eng_last  (eng_last),
      .wr_pop    (wr_pop),
      .rd_valid  (rd_valid),
      .rd_byte   (rd_byte),
      .done      (done),
      .done_ok   (done_ok)
   );

endmodule

// File: rtl/i2c_txn_seq_chk.sv
module i2c_txn_seq_chk #(
   parameter int unsigned PAUSE_CYC = 500
) (
   input logic       clk,
   input logic       rst_n,
   input logic       eng_go,
   input logic [1:0] eng_op,
   input logic       eng_last,
   input logic       eng_done,
   input logic       wr_pop,
   input logic       rd_valid,
   input logic       acq_try,
   input logic       done
);

   logic outst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) outst <= 1'b0;
      else if (eng_go) outst <= 1'b1;
      else if (eng_done) outst <= 1'b0;
   end

   // R3: never a second operation while one is outstanding
   p_single_op_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_go |-> !outst);

   // R3: issue strobe lasts one cycle
   p_go_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_go |=> !eng_go);

   // R5: a pop only accompanies a WRITE issue
   p_pop_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pop |-> (eng_go && eng_op == 2'd2));

   // R7: the NACK marker only travels with a READ
   p_last_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
      eng_last |-> (eng_op == 2'd3));

   // R7: a delivered byte follows an engine completion
   p_rdv_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(eng_done));

   // R11: completion is a single-cycle pulse
   p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   generate
      if (PAUSE_CYC > 0) begin : g_gap
         // R2: tries are separated by idle cycles
         p_try_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
            acq_try |=> !acq_try);
      end
   endgenerate

endmodule

bind i2c_txn_seq i2c_txn_seq_chk #(.PAUSE_CYC(PAUSE_CYC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .eng_go   (eng_go),
   .eng_op   (eng_op),
   .eng_last (eng_last),
   .eng_done (eng_done),
   .wr_pop   (wr_pop),
   .rd_valid (rd_valid),
   .acq_try  (acq_try),
   .done     (done)
);

// File: tb/i2c_txn_seq_test.sv
module i2c_txn_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int PL_W  = 3;
   localparam int LEN_W = 4;
   localparam int TRIES = 2;
   localparam int PAUSE = 6;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cmd_start = 1'b0;
   logic [PL_W-1:0]  cmd_count = '0;
   logic [PL_W-1:0]  desc_idx;
   logic [6:0]       desc_addr;
   logic             desc_read;
   logic [LEN_W-1:0] desc_len;
   logic             wr_pop;
   logic [7:0]       wr_byte;
   logic             rd_valid;
   logic [7:0]       rd_byte;
   logic             acq_try;
   logic             acq_ok;
   logic             eng_go;
   logic [1:0]       eng_op;
   logic [7:0]       eng_wbyte;
   logic             eng_last;
   logic             eng_done = 1'b0;
   logic             eng_ack = 1'b0;
   logic [7:0]       eng_rbyte = '0;
   logic             done;
   logic             done_ok;

   always #(CLK_PERIOD/2) clk = ~clk;

   // descriptor table and streams
   logic [6:0]       d_addr [8];
   logic             d_rd   [8];
   logic [LEN_W-1:0] d_len  [8];
   logic [7:0]       wsrc   [32];
   int               wcount;

   assign desc_addr = d_addr[desc_idx];
   assign desc_read = d_rd[desc_idx];
   assign desc_len  = d_len[desc_idx];
   assign wr_byte   = wsrc[wcount[4:0]];

   // observation logs
   logic [1:0] lg_op [64];
   logic [7:0] lg_b  [64];
   logic       lg_l  [64];
   int         n_log;
   logic [1:0] ex_op [64];
   logic [7:0] ex_b  [64];
   logic       ex_l  [64];
   int         n_ex;
   logic [7:0] rd_log [32];
   int         n_rd;
   int         done_cnt;
   logic       last_ok;
   int         try_t [8];
   int         n_try;
   int         cyc;

   // engine / arbiter behaviour knobs
   bit         start_fail, stop_fail;
   int         nack_at, wr_ops, rcount, deny_n;
   bit         pend;
   logic       pend_ack;
   logic [7:0] pend_rb;

   assign acq_ok = (n_try > deny_n);

   int tests = 0;
   int fails = 0;

   i2c_txn_seq #(
      .PL_W(PL_W), .LEN_W(LEN_W), .ACQ_TRIES(TRIES), .PAUSE_CYC(PAUSE)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_count(cmd_count),
      .desc_idx(desc_idx), .desc_addr(desc_addr), .desc_read(desc_read),
      .desc_len(desc_len), .wr_pop(wr_pop), .wr_byte(wr_byte),
      .rd_valid(rd_valid), .rd_byte(rd_byte), .acq_try(acq_try),
      .acq_ok(acq_ok), .eng_go(eng_go), .eng_op(eng_op),
      .eng_wbyte(eng_wbyte), .eng_last(eng_last), .eng_done(eng_done),
      .eng_ack(eng_ack), .eng_rbyte(eng_rbyte), .done(done),
      .done_ok(done_ok)
   );

   // bus engine, arbiter and stream model, all updated at the falling edge
   initial begin
      cyc = 0;
      pend = 1'b0;
      forever begin
         logic       nd, nack;
         logic [7:0] nrb;
         @(negedge clk);
         cyc++;
         if (rd_valid && n_rd < 32) begin rd_log[n_rd] = rd_byte; n_rd++; end
         if (done) begin done_cnt++; last_ok = done_ok; end
         if (acq_try && n_try < 8) begin try_t[n_try] = cyc; n_try++; end
         nd = pend; nack = pend_ack; nrb = pend_rb;
         pend = 1'b0;
         if (eng_go) begin
            if (n_log < 64) begin
               lg_op[n_log] = eng_op; lg_b[n_log] = eng_wbyte;
               lg_l[n_log] = eng_last; n_log++;
            end
            pend = 1'b1;
            pend_rb = 8'h00;
            case (eng_op)
               2'd0: pend_ack = !start_fail;
               2'd1: pend_ack = !stop_fail;
               2'd2: begin pend_ack = (wr_ops != nack_at); wr_ops++; end
               default: begin pend_ack = 1'b1; pend_rb = 8'hC0 + 8'(rcount); rcount++; end
            endcase
            if (wr_pop) wcount++;
         end
         eng_done = nd; eng_ack = nack; eng_rbyte = nrb;
      end
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic clr();
      n_log = 0; n_ex = 0; n_rd = 0; done_cnt = 0; n_try = 0;
      wcount = 0; wr_ops = 0; rcount = 0; deny_n = 0; nack_at = -1;
      start_fail = 1'b0; stop_fail = 1'b0; last_ok = 1'b0;
      for (int i = 0; i < 32; i++) wsrc[i] = 8'h30 + 8'(i);
   endtask

   task automatic ex(input logic [1:0] op, input logic [7:0] b, input logic l);
      ex_op[n_ex] = op; ex_b[n_ex] = b; ex_l[n_ex] = l; n_ex++;
   endtask

   task automatic cmp_ops(input string req);
      chk(n_log == n_ex, req, "operation count", n_log, n_ex);
      if (n_log == n_ex)
         for (int i = 0; i < n_ex; i++) begin
            chk(lg_op[i] == ex_op[i] && lg_b[i] == ex_b[i] && lg_l[i] == ex_l[i],
                req, $sformatf("op %0d code/byte/last", i),
                {lg_op[i], lg_b[i], lg_l[i]}, {ex_op[i], ex_b[i], ex_l[i]});
         end
   endtask

   task automatic wait_done();
      int k = 0;
      while (done_cnt == 0 && k < 3000) begin @(negedge clk); k++; end
      repeat (6) @(negedge clk);
   endtask

   task automatic run(input int cnt);
      @(negedge clk);
      cmd_count = PL_W'(cnt);
      cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      wait_done();
   endtask

   task automatic t_reset();
      chk(!done && !eng_go && !acq_try && !wr_pop && !rd_valid && desc_idx == 0,
          "R1", "idle outputs after reset",
          {done, eng_go, acq_try, wr_pop, rd_valid, 3'(desc_idx)}, 0);
   endtask

   task automatic t_write_single();
      clr();
      d_addr[0] = 7'h50; d_rd[0] = 1'b0; d_len[0] = 4'd3;
      run(1);
      ex(0, 0, 0); ex(2, 8'hA0, 0); ex(2, 8'h30, 0); ex(2, 8'h31, 0);
      ex(2, 8'h32, 0); ex(1, 0, 0);
      cmp_ops("R4 R5 R8");
      chk(wcount == 3, "R5", "bytes popped", wcount, 3);
      chk(done_cnt == 1 && last_ok, "R8", "done ok", {done_cnt, last_ok}, {32'd1, 1'b1});
   endtask

   task automatic t_write_read();
      clr();
      d_addr[0] = 7'h21; d_rd[0] = 1'b0; d_len[0] = 4'd1;
      d_addr[1] = 7'h21; d_rd[1] = 1'b1; d_len[1] = 4'd3;
      run(2);
      ex(0, 0, 0); ex(2, 8'h42, 0); ex(2, 8'h30, 0);
      ex(0, 0, 0); ex(2, 8'h43, 0);
      ex(3, 0, 0); ex(3, 0, 0); ex(3, 0, 1); ex(1, 0, 0);
      cmp_ops("R3 R7 R8");
      chk(n_rd == 3, "R7", "read bytes delivered", n_rd, 3);
      for (int i = 0; i < 3 && i < n_rd; i++)
         chk(rd_log[i] == 8'hC0 + 8'(i), "R7", "read byte order", rd_log[i], 8'hC0 + i);
      chk(done_cnt == 1 && last_ok, "R8", "done ok", {done_cnt, last_ok}, {32'd1, 1'b1});
   endtask

   task automatic t_nack_data();
      clr();
      d_addr[0] = 7'h50; d_rd[0] = 1'b0; d_len[0] = 4'd3;
      d_addr[1] = 7'h51; d_rd[1] = 1'b1; d_len[1] = 4'd2;
      nack_at = 2;
      run(2);
      ex(0, 0, 0); ex(2, 8'hA0, 0); ex(2, 8'h30, 0); ex(2, 8'h31, 0); ex(1, 0, 0);
      cmp_ops("R6");
      chk(done_cnt == 1 && !last_ok, "R6", "data NACK fails", last_ok, 0);
   endtask

   task automatic t_nack_addr();
      clr();
      d_addr[0] = 7'h10; d_rd[0] = 1'b0; d_len[0] = 4'd1;
      d_addr[1] = 7'h11; d_rd[1] = 1'b0; d_len[1] = 4'd2;
      d_addr[2] = 7'h12; d_rd[2] = 1'b0; d_len[2] = 4'd1;
      nack_at = 2;
      run(3);
      ex(0, 0, 0); ex(2, 8'h20, 0); ex(2, 8'h30, 0);
      ex(0, 0, 0); ex(2, 8'h22, 0); ex(1, 0, 0);
      cmp_ops("R6");
      chk(wcount == 1, "R6", "no pop after failure", wcount, 1);
      chk(done_cnt == 1 && !last_ok, "R6", "address NACK fails", last_ok, 0);
   endtask

   task automatic t_zero_len();
      clr();
      d_addr[0] = 7'h3C; d_rd[0] = 1'b1; d_len[0] = 4'd0;
      run(1);
      ex(0, 0, 0); ex(2, 8'h79, 0); ex(1, 0, 0);
      cmp_ops("R10");
      chk(done_cnt == 1 && last_ok, "R10", "zero-length ok", last_ok, 1);
      clr();
      d_addr[0] = 7'h3C; d_rd[0] = 1'b0; d_len[0] = 4'd0;
      nack_at = 0;
      run(1);
      chk(done_cnt == 1 && !last_ok, "R10", "zero-length address NACK", last_ok, 0);
   endtask

   task automatic t_acq_deny();
      clr();
      deny_n = 2;
      d_addr[0] = 7'h50; d_rd[0] = 1'b0; d_len[0] = 4'd1;
      run(1);
      chk(n_try == 2, "R2", "tries", n_try, 2);
      if (n_try == 2)
         chk(try_t[1] - try_t[0] == PAUSE + 1, "R2", "try spacing",
             try_t[1] - try_t[0], PAUSE + 1);
      chk(n_log == 0, "R2", "no engine ops", n_log, 0);
      chk(done_cnt == 1 && !last_ok, "R2", "refused fails", last_ok, 0);
   endtask

   task automatic t_acq_retry();
      clr();
      deny_n = 1;
      d_addr[0] = 7'h50; d_rd[0] = 1'b0; d_len[0] = 4'd1;
      run(1);
      chk(n_try == 2, "R2", "second try granted", n_try, 2);
      ex(0, 0, 0); ex(2, 8'hA0, 0); ex(2, 8'h30, 0); ex(1, 0, 0);
      cmp_ops("R2");
      chk(done_cnt == 1 && last_ok, "R2", "ok after retry", last_ok, 1);
   endtask

   task automatic t_cond_fail();
      clr();
      stop_fail = 1'b1;
      d_addr[0] = 7'h50; d_rd[0] = 1'b0; d_len[0] = 4'd0;
      run(1);
      chk(done_cnt == 1 && !last_ok, "R9", "failed STOP", last_ok, 0);
      clr();
      start_fail = 1'b1;
      d_addr[0] = 7'h50; d_rd[0] = 1'b0; d_len[0] = 4'd2;
      run(2);
      ex(0, 0, 0); ex(1, 0, 0);
      cmp_ops("R9");
      chk(done_cnt == 1 && !last_ok, "R9", "failed START", last_ok, 0);
   endtask

   task automatic t_busy_ignore();
      clr();
      d_addr[0] = 7'h50; d_rd[0] = 1'b0; d_len[0] = 4'd2;
      @(negedge clk);
      cmd_count = 3'd1; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      repeat (8) @(negedge clk);
      cmd_count = 3'd3; cmd_start = 1'b1;
      @(negedge clk);
      cmd_start = 1'b0;
      wait_done();
      repeat (20) @(negedge clk);
      ex(0, 0, 0); ex(2, 8'hA0, 0); ex(2, 8'h30, 0); ex(2, 8'h31, 0); ex(1, 0, 0);
      cmp_ops("R11");
      chk(done_cnt == 1, "R11", "single done pulse", done_cnt, 1);
   endtask

   task automatic t_zero_cmd();
      clr();
      run(0);
      chk(done_cnt == 1 && last_ok, "R12", "empty command ok", last_ok, 1);
      chk(n_try == 0 && n_log == 0, "R12", "no bus activity", n_try + n_log, 0);
   endtask

   initial begin
      for (int i = 0; i < 8; i++) begin
         d_addr[i] = '0; d_rd[i] = 1'b0; d_len[i] = '0;
      end
      clr();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_write_single();
      t_write_read();
      t_nack_data();
      t_nack_addr();
      t_zero_len();
      t_acq_deny();
      t_acq_retry();
      t_cond_fail();
      t_busy_ignore();
      t_zero_cmd();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule